// File: doc/BRIEF.md
# Clock Phase Alignment Sweep Controller

This block finds a good phase for an internal fabric clock relative to an incoming converter clock. It drives a phase shifter through a step-and-acknowledge handshake. At every setting it runs a clock self-test on the two bits captured from the converter clock image on the rising and falling edges. It then settles the shifter on the middle of the widest passing window.

A single start pulse, normally raised by a local bus register write, launches a sweep. The controller first walks the shifter from its present setting down to the most negative end of the range. It then tests each setting in turn while stepping upward to the top of the range. Next it picks the centre of the longest run of passing settings and steps back down to it. Finally it holds a done flag, a success flag and the applied setting index until the next sweep. If no setting passes, it returns the shifter to where the sweep began and reports failure. The shifter model, the clock buffers and the bus decoder are not part of the block.

Setting indices run from 0 (most negative) to STEPS-1. After reset the shifter is taken to sit at index STEPS/2.

Top module: `phase_align_top`

## Requirements
- R1: After reset the block stays idle until a start pulse arrives: busy_o, done_o and success_o are 0 and ps_en_o never rises.
- R2: A start pulse while idle raises busy_o on the next cycle and clears done_o. Start pulses while busy_o is 1 have no effect on the step sequence or the result.
- R3: ps_en_o is high for exactly one cycle per step, with ps_inc_o giving the direction (1 = up one index, 0 = down one). No further ps_en_o pulse is issued until ps_done_i has acknowledged the previous one.
- R4: A sweep begins with one decrement for each index above 0 at the present setting. It then performs STEPS-1 increments, testing every index from 0 to STEPS-1.
- R5: A setting passes only if all TEST_CYCLES captured pairs equal rise=1, fall=0. A single mismatching pair fails that setting.
- R6: After each step acknowledge, and after the initial descent, the controller waits at least SETTLE_CYCLES cycles before sampling starts. Pairs captured while a step is in flight or just completing are never counted.
- R7: The chosen setting is start + (len-1)/2 (integer division) for the longest run of consecutive passing indices. If runs tie, the one with the lowest start index wins.
- R8: After the sweep the controller steps down from index STEPS-1 to the chosen setting using only decrements, and reports that index on result_pos_o.
- R9: If no index passes, success_o is 0 and the shifter is returned to the index it held when the sweep started. result_pos_o shows that index.
- R10: At completion busy_o falls in the same cycle that done_o rises. done_o, success_o and result_pos_o hold until the next accepted start, and success_o is never 1 without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a sweep |
| ddr_rise_i | input | 1 | Clock image bit captured on the rising edge |
| ddr_fall_i | input | 1 | Clock image bit captured on the falling edge |
| ps_en_o | output | 1 | One-cycle phase step request |
| ps_inc_o | output | 1 | Step direction, 1 = increment |
| ps_done_i | input | 1 | Shifter acknowledge for the outstanding step |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Last sweep finished |
| success_o | output | 1 | Last sweep found a passing window |
| result_pos_o | output | $clog2(STEPS) | Setting index applied by the last sweep |

## Verification
The checker assumes that the shifter answers each step request with exactly one single-cycle acknowledge. It also assumes that no acknowledge arrives while no step is outstanding. Its step-ordering property relies on this. The bench's shifter model keeps to this contract: it raises ps_done_i for one cycle, two cycles after each request, and it spoils the clock image while a step is pending and in the acknowledge cycle. Start pulses are sent only as single cycles, either while idle or deliberately in the middle of a sweep.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_DESCEND,
        CS_SETTLE,
        CS_TEST,
        CS_ADVANCE,
        CS_PICK,
        CS_RETURN
    } ctrl_state_e;

    typedef enum logic {
        DS_IDLE,
        DS_WAIT
    } drv_state_e;

endpackage

// File: rtl/pa_clk_sampler.sv
module pa_clk_sampler #(
    parameter int unsigned TEST_CYCLES = 256,
    parameter bit          EXP_RISE    = 1'b1,
    parameter bit          EXP_FALL    = 1'b0,
    parameter bit          IN_REG      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic done_o,
    output logic pass_o,
    output logic fail_o
);
    localparam int unsigned CW = $clog2(TEST_CYCLES + 1);

    logic rise_s, fall_s;

    // optional capture stage standing for the edge-pair register output
    generate
        if (IN_REG) begin : g_cap
            logic rise_q, fall_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rise_q <= 1'b0;
                    fall_q <= 1'b0;
                end else begin
                    rise_q <= rise_i;
                    fall_q <= fall_i;
                end
            end
            assign rise_s = rise_q;
            assign fall_s = fall_q;
        end else begin : g_nocap
            assign rise_s = rise_i;
            assign fall_s = fall_i;
        end
    endgenerate

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          bad;
        logic          done;
        logic          pass;
        logic          fail;
    } smp_t;

    smp_t s_d, s_q;
    logic mismatch;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        mismatch = (rise_s != EXP_RISE) || (fall_s != EXP_FALL);
        if (start_i) begin
            s_d.run  = 1'b1;
            s_d.cnt  = CW'(TEST_CYCLES);
            s_d.bad  = 1'b0;
            s_d.pass = 1'b0;
            s_d.fail = 1'b0;
        end else if (s_q.run) begin
            if (s_q.cnt == CW'(1)) begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
                s_d.pass = !(s_q.bad || mismatch);
                s_d.fail = s_q.bad || mismatch;
            end else begin
                s_d.bad = s_q.bad || mismatch;
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign pass_o = s_q.pass;
    assign fail_o = s_q.fail;
endmodule

// File: rtl/pa_step_driver.sv
module pa_step_driver (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic inc_i,
    output logic ack_o,
    output logic ps_en_o,
    output logic ps_inc_o,
    input  logic ps_done_i
);
    import pa_pkg::*;

    typedef struct packed {
        drv_state_e st;
        logic       en;
        logic       inc;
        logic       ack;
    } drv_t;

    drv_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.en  = 1'b0;
        r_d.ack = 1'b0;
        unique case (r_q.st)
            DS_IDLE: begin
                if (req_i) begin
                    r_d.en  = 1'b1;
                    r_d.inc = inc_i;
                    r_d.st  = DS_WAIT;
                end
            end
            DS_WAIT: begin
                if (ps_done_i) begin
                    r_d.ack = 1'b1;
                    r_d.st  = DS_IDLE;
                end
            end
            default: r_d.st = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: DS_IDLE, en: 1'b0, inc: 1'b0, ack: 1'b0};
        else        r_q <= r_d;
    end

    assign ack_o    = r_q.ack;
    assign ps_en_o  = r_q.en;
    assign ps_inc_o = r_q.inc;
endmodule

// File: rtl/pa_sweep_ctrl.sv
module pa_sweep_ctrl #(
    parameter int unsigned STEPS         = 64,
    parameter int unsigned SETTLE_CYCLES = 4,
    localparam int unsigned IW           = $clog2(STEPS),
    localparam int unsigned LW           = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          step_req_o,
    output logic          step_inc_o,
    input  logic          step_ack_i,
    output logic          test_start_o,
    input  logic          test_done_i,
    input  logic          test_pass_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          success_o,
    output logic [IW-1:0] result_o
);
    import pa_pkg::*;

    localparam int unsigned SW        = $clog2(SETTLE_CYCLES + 1);
    localparam logic [IW-1:0] TOP_POS = IW'(STEPS - 1);
    localparam logic [IW-1:0] MID_POS = IW'(STEPS / 2);

    typedef struct packed {
        ctrl_state_e   st;
        logic [IW-1:0] pos;
        logic [IW-1:0] home;
        logic [LW-1:0] rem;
        logic [SW-1:0] settle;
        logic          wait_ack;
        logic [IW-1:0] cur_start;
        logic [LW-1:0] cur_len;
        logic [IW-1:0] best_start;
        logic [LW-1:0] best_len;
        logic [IW-1:0] target;
        logic          found;
        logic          busy;
        logic          done;
        logic          success;
        logic [IW-1:0] result;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [LW-1:0] run_len;
    logic [IW-1:0] run_start;

    always_comb begin
        c_d          = c_q;
        step_req_o   = 1'b0;
        step_inc_o   = 1'b0;
        test_start_o = 1'b0;
        run_len      = c_q.cur_len + LW'(1);
        run_start    = (c_q.cur_len == '0) ? c_q.pos : c_q.cur_start;

        unique case (c_q.st)
            CS_IDLE: begin
                if (start_i) begin
                    c_d.st       = CS_DESCEND;
                    c_d.busy     = 1'b1;
                    c_d.done     = 1'b0;
                    c_d.success  = 1'b0;
                    c_d.home     = c_q.pos;
                    c_d.rem      = LW'(c_q.pos);
                    c_d.wait_ack = 1'b0;
                    c_d.cur_len  = '0;
                    c_d.best_len = '0;
                    c_d.cur_start  = '0;
                    c_d.best_start = '0;
                end
            end

            CS_DESCEND, CS_RETURN: begin
                if (c_q.rem == '0) begin
                    if (c_q.st == CS_DESCEND) begin
                        c_d.st     = CS_SETTLE;
                        c_d.settle = SW'(SETTLE_CYCLES);
                    end else begin
                        c_d.st      = CS_IDLE;
                        c_d.busy    = 1'b0;
                        c_d.done    = 1'b1;
                        c_d.success = c_q.found;
                        c_d.result  = c_q.pos;
                    end
                end else if (!c_q.wait_ack) begin
                    step_req_o   = 1'b1;
                    step_inc_o   = 1'b0;
                    c_d.wait_ack = 1'b1;
                end else if (step_ack_i) begin
                    c_d.wait_ack = 1'b0;
                    c_d.rem      = c_q.rem - LW'(1);
                    c_d.pos      = c_q.pos - IW'(1);
                end
            end

            CS_SETTLE: begin
                if (c_q.settle == '0) begin
                    test_start_o = 1'b1;
                    c_d.st       = CS_TEST;
                end else begin
                    c_d.settle = c_q.settle - SW'(1);
                end
            end

            CS_TEST: begin
                if (test_done_i) begin
                    if (test_pass_i) begin
                        c_d.cur_len   = run_len;
                        c_d.cur_start = run_start;
                        if (run_len > c_q.best_len) begin
                            c_d.best_len   = run_len;
                            c_d.best_start = run_start;
                        end
                    end else begin
                        c_d.cur_len = '0;
                    end
                    c_d.wait_ack = 1'b0;
                    c_d.st = (c_q.pos == TOP_POS) ? CS_PICK : CS_ADVANCE;
                end
            end

            CS_ADVANCE: begin
                if (!c_q.wait_ack) begin
                    step_req_o   = 1'b1;
                    step_inc_o   = 1'b1;
                    c_d.wait_ack = 1'b1;
                end else if (step_ack_i) begin
                    c_d.wait_ack = 1'b0;
                    c_d.pos      = c_q.pos + IW'(1);
                    c_d.settle   = SW'(SETTLE_CYCLES);
                    c_d.st       = CS_SETTLE;
                end
            end

            CS_PICK: begin
                if (c_q.best_len == '0) begin
                    c_d.found  = 1'b0;
                    c_d.target = c_q.home;
                end else begin
                    c_d.found  = 1'b1;
                    c_d.target = c_q.best_start
                               + IW'((c_q.best_len - LW'(1)) >> 1);
                end
                c_d.st       = CS_RETURN;
                c_d.wait_ack = 1'b0;
                c_d.rem      = LW'(c_q.pos) - LW'(c_d.target);
            end

            default: c_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= CS_IDLE;
            c_q.pos <= MID_POS;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o    = c_q.busy;
    assign done_o    = c_q.done;
    assign success_o = c_q.success;
    assign result_o  = c_q.result;
endmodule

// File: rtl/phase_align_top.sv
module phase_align_top #(
    parameter int unsigned STEPS         = 64,
    parameter int unsigned TEST_CYCLES   = 256,
    parameter int unsigned SETTLE_CYCLES = 4,
    localparam int unsigned IW           = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          ddr_rise_i,
    input  logic          ddr_fall_i,
    output logic          ps_en_o,
    output logic          ps_inc_o,
    input  logic          ps_done_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          success_o,
    output logic [IW-1:0] result_pos_o
);
    logic step_req, step_inc, step_ack;
    logic test_start, test_done, test_pass, test_fail;

    pa_sweep_ctrl #(
        .STEPS         (STEPS),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .step_req_o   (step_req),
        .step_inc_o   (step_inc),
        .step_ack_i   (step_ack),
        .test_start_o (test_start),
        .test_done_i  (test_done),
        .test_pass_i  (test_pass),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .success_o    (success_o),
        .result_o     (result_pos_o)
    );

    pa_step_driver u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (step_req),
        .inc_i     (step_inc),
        .ack_o     (step_ack),
        .ps_en_o   (ps_en_o),
        .ps_inc_o  (ps_inc_o),
        .ps_done_i (ps_done_i)
    );

    pa_clk_sampler #(
        .TEST_CYCLES (TEST_CYCLES),
        .EXP_RISE    (1'b1),
        .EXP_FALL    (1'b0),
        .IN_REG      (1'b1)
    ) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (test_start),
        .rise_i  (ddr_rise_i),
        .fall_i  (ddr_fall_i),
        .done_o  (test_done),
        .pass_o  (test_pass),
        .fail_o  (test_fail)
    );

    logic unused_fail;
    assign unused_fail = test_fail;
endmodule

// File: rtl/pa_align_checker.sv
module pa_align_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ps_en_o,
    input logic ps_done_i,
    input logic busy_o,
    input logic done_o,
    input logic success_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (ps_en_o)   pend_q <= 1'b1;
        else if (ps_done_i) pend_q <= 1'b0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ps_en_o);                                   // R1
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));           // R2
    AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ps_en_o |=> !ps_en_o);                                   // R3
    AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !ps_en_o);                                    // R3
    AST_DONE_EXCL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                     // R10
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);                               // R10
    AST_SUCCESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        success_o |-> done_o);                                   // R10
endmodule

bind phase_align_top pa_align_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ps_en_o   (ps_en_o),
    .ps_done_i (ps_done_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .success_o (success_o)
);

// File: tb/phase_align_top_tb.sv
module phase_align_top_tb;
    localparam int STEPS  = 16;
    localparam int TESTC  = 8;
    localparam int SETTLE = 2;
    localparam int IW     = $clog2(STEPS);
    localparam int LIMIT  = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ddr_rise_i = 1'b0;
    logic ddr_fall_i = 1'b1;
    logic ps_done_i = 1'b0;
    logic ps_en_o, ps_inc_o, busy_o, done_o, success_o;
    logic [IW-1:0] result_pos_o;

    always #10 clk = ~clk;

    phase_align_top #(
        .STEPS(STEPS), .TEST_CYCLES(TESTC), .SETTLE_CYCLES(SETTLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ddr_rise_i(ddr_rise_i), .ddr_fall_i(ddr_fall_i),
        .ps_en_o(ps_en_o), .ps_inc_o(ps_inc_o), .ps_done_i(ps_done_i),
        .busy_o(busy_o), .done_o(done_o), .success_o(success_o),
        .result_pos_o(result_pos_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // shifter and clock image model
    logic [STEPS-1:0] pass_map = '0;
    int flaky_idx = -1;
    int pos = STEPS / 2;
    bit pend = 0, glitch = 0, dir = 0;
    int dly = 0;
    int en_total = 0;
    int viol = 0;

    always @(negedge clk) begin
        bit good;
        if (!rst_n) begin
            pend = 0; glitch = 0; ps_done_i = 0;
        end else if (ps_en_o) begin
            if (pend) viol++;
            pend = 1; dir = ps_inc_o; dly = 2;
            ps_done_i = 0; glitch = 0;
            en_total++;
        end else if (pend) begin
            dly--;
            if (dly == 0) begin
                pend = 0; ps_done_i = 1; glitch = 1;
                pos = dir ? pos + 1 : pos - 1;
            end
        end else begin
            ps_done_i = 0; glitch = 0;
        end
        good = !pend && !glitch && pos >= 0 && pos < STEPS;
        if (good) good = pass_map[pos];
        if (good && pos == flaky_idx && (cyc % 7) == 0) good = 0;
        ddr_rise_i = good;
        ddr_fall_i = !good;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, act=%0d exp=<%0d", cyc, LIMIT);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // expected chosen index: centre of longest run, earliest on tie (R7)
    function automatic int best_of(input logic [STEPS-1:0] m);
        int bl = 0, bs = 0, cl = 0, cs = 0;
        for (int i = 0; i < STEPS; i++) begin
            if (m[i]) begin
                if (cl == 0) cs = i;
                cl++;
                if (cl > bl) begin bl = cl; bs = cs; end
            end else cl = 0;
        end
        return (bl == 0) ? -1 : bs + (bl - 1) / 2;
    endfunction

    task automatic sweep(input logic [STEPS-1:0] m, input int flaky, input bit poke);
        int p0, e0, exp_pos, exp_en, w;
        bit exp_ok;
        logic [STEPS-1:0] eff;
        pass_map = m; flaky_idx = flaky;
        eff = m;
        if (flaky >= 0) eff[flaky] = 1'b0;      // R5: one bad pair fails it
        p0 = pos; e0 = en_total;
        w = best_of(eff);
        exp_ok  = (w >= 0);
        exp_pos = exp_ok ? w : p0;
        exp_en  = p0 + (STEPS - 1) + (STEPS - 1 - exp_pos);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(busy_o === 1'b1 && done_o === 1'b0, "R2 busy after start", busy_o, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        while (done_o !== 1'b1 && cyc < LIMIT) @(negedge clk);
        chk(success_o === exp_ok, exp_ok ? "R7 success" : "R9 failure flag", success_o, exp_ok);
        chk(pos == exp_pos, exp_ok ? "R7 shifter at centre" : "R9 shifter home", pos, exp_pos);
        chk(result_pos_o == exp_pos, "R8 result index", result_pos_o, exp_pos);
        chk(en_total - e0 == exp_en, poke ? "R2 start ignored, step count" : "R4 step count",
            en_total - e0, exp_en);
        chk(viol == 0, "R3 step before acknowledge", viol, 0);
        chk(busy_o === 1'b0, "R10 busy clear at done", busy_o, 0);
        repeat (3) @(negedge clk);
        chk(done_o === 1'b1 && result_pos_o == exp_pos, "R10 result held", done_o, 1);
    endtask

    initial begin
        logic [STEPS-1:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (25) @(negedge clk);
        chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
        chk(done_o === 1'b0, "R1 done after reset", done_o, 0);
        chk(success_o === 1'b0, "R1 success after reset", success_o, 0);
        chk(en_total == 0, "R1 no step without start", en_total, 0);

        // R9: nothing passes, shifter returns to index 8
        sweep('0, -1, 0);
        // R7: whole range passes, centre 7
        sweep('1, -1, 0);
        // R7: tie between two runs of three, earliest wins
        sweep(16'h00E7, -1, 0);
        // R5/R6: flaky setting splits a window
        sweep(16'h0FF0, 7, 0);
        // R2: extra start in the middle of a sweep
        sweep(16'h03C0, -1, 1);
        // R4/R7/R8: every contiguous window
        for (int lo = 0; lo < STEPS; lo++) begin
            for (int hi = lo; hi < STEPS; hi++) begin
                m = '0;
                for (int b = lo; b <= hi; b++) m[b] = 1'b1;
                sweep(m, -1, 0);
            end
        end
        // R9 again from a non-centre home
        sweep('0, -1, 0);
        finished = 1;
        summary();
    end
endmodule